// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers interrupt requests from 43 sources and hands one of them at a time to a CPU. The sources are a non-maskable input (active low, edge-triggered), six external request pins, and 36 internal peripheral request lines. The peripheral lines are grouped as one watchdog line, one refresh-timer line, nine 16-bit timer lines, eight 8-bit timer lines, four DMA lines, twelve serial lines and one converter line. Every request is captured in a pending flag. The flag stays set until the CPU acknowledges that source, so a request pulse of one cycle is not lost.

Each maskable source belongs to a group. Each group has one bit in a pair of 8-bit priority registers, and that bit places the group at the high or the low level. The CPU supplies two mask inputs. One blocks every maskable source. The other blocks only low-level sources. The non-maskable source ignores enables, levels and masks, and it always wins. Ties inside a level are resolved by a fixed order.

The winner is presented as a registered request flag and a vector number. Both hold until the CPU gives a one-cycle acknowledge. The acknowledge clears only the pending flag of the granted source. Software sets the priority bits and the per-source enables through a small synchronous write port.

Top module: `two_level_intc`

## Requirements
- R1: After synchronous reset, `irq_req` is 0 and `irq_vec` is 0. All priority bits read as low and all source enables are off, so a maskable request after reset produces no grant.
- R2: A write with `wr_en` high stores `wr_data` in the next clock edge. Address 0 is priority register A (groups 0-7) and address 1 is priority register B (groups 8-15). Addresses 2 to 7 hold the enables: source s (1..42) is enabled by address 2+(s-1)/8, bit (s-1)%8.
- R3: A falling edge on `nmi_n` sets the pending flag of source 0. That flag is not affected by enables, levels, `mask_all` or `mask_low`. A pending source 0 wins over all others and is granted with vector `VEC_BASE`. Holding `nmi_n` low does not raise a second request.
- R4: Group map: pin requests 0-5 use groups 0-5, watchdog and refresh timer use group 6, converter uses group 7, 16-bit timer channels of 3 lines use groups 8-10, 8-bit timer channels of 4 lines use groups 11-12, DMA uses group 13, serial channel 0 uses group 14, and serial channels 1 and 2 use group 15. A group bit of 1 means high level.
- R5: When both levels have eligible pending sources, a high-level source is granted before any low-level source.
- R6: Within one level, the lowest source index wins. Pin requests therefore come before internal lines, and internal lines go in ascending order.
- R7: While `mask_all` is 1, no maskable source is granted.
- R8: While `mask_low` is 1, low-level sources are not granted, but high-level sources still are.
- R9: A request on a disabled source is not latched. Enabling the source later does not produce a grant.
- R10: A request held for one cycle on an enabled source is latched. It is presented two clock edges after it is sampled.
- R11: `irq_req` and `irq_vec` stay stable until `irq_ack` is high while `irq_req` is 1. The ack drops `irq_req` on the next edge and clears only the granted source's pending flag. The next grant appears one edge later. An ack while `irq_req` is 0 is ignored.
- R12: The vector is `VEC_BASE` plus the source index. Index 0 is the non-maskable input, 1-6 are pin requests 0-5, and 7+k is peripheral line k (k = 0..35).
- R13: If a source's request is high in the same cycle as its acknowledge, the set wins. The source stays pending and is granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| nmi_n | input | 1 | Non-maskable request, falling-edge sensitive |
| irq_in | input | 6 | External pin requests 0-5 |
| periph_req | input | 36 | Internal peripheral request lines |
| mask_all | input | 1 | CPU mask for all maskable sources |
| mask_low | input | 1 | CPU mask for low-level sources only |
| irq_ack | input | 1 | One-cycle acknowledge from the CPU |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | 8 | Vector number of the granted source |

## Verification
Two events can fall in the same cycle: the acknowledge of a granted source, and a fresh request from that same source or from a competitor. The bench holds pin request 0 high through its own acknowledge. It then expects `irq_req` to drop for exactly one edge and to return with the same vector, which shows that the set beats the clear. A second case latches two sources and acknowledges the first. It expects the second to be presented one edge later, which shows that the acknowledge cleared only the granted flag.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int N_IRQ      = 6;
  localparam int N_INT      = 36;
  localparam int N_SRC      = 1 + N_IRQ + N_INT;
  localparam int N_MSK      = N_SRC - 1;
  localparam int IDX_W      = $clog2(N_SRC);
  localparam int REG_W      = 8;
  localparam int N_GRP      = 2 * REG_W;
  localparam int ADDR_W     = 3;
  localparam int EN_BASE    = 2;

  localparam int S_WDT      = 1 + N_IRQ;
  localparam int S_DRAM     = S_WDT + 1;
  localparam int S_T16      = S_DRAM + 1;
  localparam int T16_CH     = 3;
  localparam int S_T8       = S_T16 + 3 * T16_CH;
  localparam int T8_CH      = 4;
  localparam int S_DMA      = S_T8 + 2 * T8_CH;
  localparam int S_SCI      = S_DMA + 4;
  localparam int SCI_CH     = 4;
  localparam int S_ADC      = S_SCI + 3 * SCI_CH;

  function automatic int src_group(input int s);
    if (s < S_WDT)           return s - 1;
    else if (s <= S_DRAM)    return 6;
    else if (s == S_ADC)     return 7;
    else if (s < S_T8)       return 8 + (s - S_T16) / T16_CH;
    else if (s < S_DMA)      return 11 + (s - S_T8) / T8_CH;
    else if (s < S_SCI)      return 13;
    else if (s < S_SCI + SCI_CH) return 14;
    else                     return 15;
  endfunction
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
  import intc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = REG_W,
  parameter int NE = N_MSK
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic [2*DW-1:0] prio,
  output logic [NE-1:0]   en
);
  logic [2*DW-1:0] prio_q;
  logic [NE-1:0]   en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(0)) prio_q[DW-1:0]    <= wr_data;
      if (wr_addr == AW'(1)) prio_q[2*DW-1:DW] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else begin
      for (int b = 0; b < NE; b++) begin
        if (wr_en && wr_addr == AW'(EN_BASE + b / DW))
          en_q[b] <= wr_data[b % DW];
      end
    end
  end

  assign prio = prio_q;
  assign en   = en_q;

  AST_PRIO_A_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == AW'(0)) |=> (prio_q[DW-1:0] == $past(wr_data))); // R2
  AST_EN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(en_q)); // R2
endmodule

// File: rtl/intc_pend.sv
module intc_pend
  import intc_pkg::*;
#(
  parameter int NM = N_MSK,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nmi_n,
  input  logic [NM-1:0] req,
  input  logic [NM-1:0] en,
  input  logic          clr_valid,
  input  logic [IW-1:0] clr_idx,
  output logic [NM:0]   pend
);
  logic        nmi_prev_q;
  logic [NM:0] pend_q;
  logic [NM:0] set_v;

  always_ff @(posedge clk) begin
    if (rst) nmi_prev_q <= 1'b1;
    else     nmi_prev_q <= nmi_n;
  end

  assign set_v[0] = nmi_prev_q & ~nmi_n;

  genvar i;
  generate
    for (i = 1; i <= NM; i++) begin : g_set
      assign set_v[i] = req[i-1] & en[i-1];
    end
    for (i = 0; i <= NM; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst)
          pend_q[i] <= 1'b0;
        else if (set_v[i])
          pend_q[i] <= 1'b1;
        else if (clr_valid && clr_idx == IW'(i))
          pend_q[i] <= 1'b0;
      end
    end
    for (i = 1; i <= NM; i++) begin : g_chk
      AST_DISABLED_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
        (!pend_q[i] && !en[i-1]) |=> !pend_q[i]); // R9
    end
  endgenerate

  assign pend = pend_q;

  AST_NMI_LATCH: assert property (@(posedge clk) disable iff (rst)
    $fell(nmi_n) |=> pend_q[0]); // R3
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int N = 42,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/two_level_intc.sv
module two_level_intc
  import intc_pkg::*;
#(
  parameter int VEC_BASE = 7,
  parameter int VEC_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              nmi_n,
  input  logic [N_IRQ-1:0]  irq_in,
  input  logic [N_INT-1:0]  periph_req,
  input  logic              mask_all,
  input  logic              mask_low,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec
);
  localparam int PW = $clog2(N_MSK);

  logic [N_GRP-1:0] prio;
  logic [N_MSK-1:0] en;
  logic [N_SRC-1:0] pend;
  logic [N_MSK-1:0] lvl;
  logic [N_SRC-1:0] lvl_full;
  logic [N_MSK-1:0] elig, cand_hi, cand_lo;
  logic             hi_found, lo_found;
  logic [PW-1:0]    hi_idx, lo_idx;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  logic             req_q;
  logic [IDX_W-1:0] idx_q;
  logic [VEC_W-1:0] vec_q;

  intc_cfg_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .prio(prio), .en(en)
  );

  intc_pend u_pend (
    .clk(clk), .rst(rst), .nmi_n(nmi_n), .req({periph_req, irq_in}),
    .en(en), .clr_valid(req_q & irq_ack), .clr_idx(idx_q), .pend(pend)
  );

  genvar s;
  generate
    for (s = 1; s < N_SRC; s++) begin : g_lvl
      assign lvl[s-1] = prio[src_group(s)];
    end
  endgenerate
  assign lvl_full = {lvl, 1'b1};

  assign elig    = pend[N_SRC-1:1] & en & {N_MSK{~mask_all}};
  assign cand_hi = elig & lvl;
  assign cand_lo = elig & ~lvl & {N_MSK{~mask_low}};

  intc_pick #(.N(N_MSK), .W(PW)) u_pick_hi (
    .req(cand_hi), .found(hi_found), .idx(hi_idx)
  );
  intc_pick #(.N(N_MSK), .W(PW)) u_pick_lo (
    .req(cand_lo), .found(lo_found), .idx(lo_idx)
  );

  always_comb begin
    win_valid = pend[0] | hi_found | lo_found;
    if (pend[0])       win_idx = '0;
    else if (hi_found) win_idx = IDX_W'(hi_idx) + IDX_W'(1);
    else               win_idx = IDX_W'(lo_idx) + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      idx_q <= '0;
      vec_q <= '0;
    end else if (req_q) begin
      if (irq_ack) req_q <= 1'b0;
    end else if (win_valid) begin
      req_q <= 1'b1;
      idx_q <= win_idx;
      vec_q <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
    end
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec))); // R11
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    (irq_req && irq_ack) |=> !irq_req); // R11
  AST_NMI_WINS: assert property (@(posedge clk) disable iff (rst)
    (!irq_req && pend[0]) |=> (irq_req && irq_vec == VEC_W'(VEC_BASE))); // R3
  AST_MASK_ALL: assert property (@(posedge clk) disable iff (rst)
    (!irq_req && mask_all) |=> (!irq_req || idx_q == '0)); // R7
  AST_MASK_LOW: assert property (@(posedge clk) disable iff (rst)
    (!irq_req && mask_low) |=> (!irq_req || lvl_full[idx_q])); // R8
  AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!irq_req && hi_found) |=> lvl_full[idx_q]); // R5
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec >= VEC_W'(VEC_BASE) &&
                 irq_vec <  VEC_W'(VEC_BASE + N_SRC))); // R12
endmodule

// File: tb/sim_two_level_intc.sv
`timescale 1ns/1ps
module sim_two_level_intc;
  localparam int NROW = 12;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;
  logic        nmi_n;
  logic [5:0]  irq_in;
  logic [35:0] periph_req;
  logic        mask_all, mask_low, irq_ack;
  logic        irq_req;
  logic [7:0]  irq_vec;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  two_level_intc u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .nmi_n(nmi_n), .irq_in(irq_in), .periph_req(periph_req),
    .mask_all(mask_all), .mask_low(mask_low), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  // {prioA, prioB, mask_all, mask_low, nmi_fall, irq[5:0], periph[35:0], exp_req, exp_vec}
  localparam logic [69:0] TBL [NROW] = '{
    {8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 6'b001000, 36'h000000000, 1'b1, 8'd11},
    {8'h10, 8'h00, 1'b0, 1'b0, 1'b0, 6'b010010, 36'h000000000, 1'b1, 8'd12},
    {8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 6'b010010, 36'h000000000, 1'b1, 8'd9},
    {8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 6'b100000, 36'h000000001, 1'b1, 8'd13},
    {8'h80, 8'h00, 1'b0, 1'b0, 1'b0, 6'b000000, 36'h800000004, 1'b1, 8'd49},
    {8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 6'b000001, 36'h000000000, 1'b0, 8'd0},
    {8'h01, 8'h00, 1'b1, 1'b0, 1'b1, 6'b000001, 36'h000000000, 1'b1, 8'd7},
    {8'h04, 8'h00, 1'b0, 1'b1, 1'b0, 6'b000101, 36'h000000000, 1'b1, 8'd10},
    {8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 6'b000001, 36'h000000000, 1'b0, 8'd0},
    {8'h00, 8'h80, 1'b0, 1'b0, 1'b0, 6'b000000, 36'h400080000, 1'b1, 8'd48},
    {8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 6'b000000, 36'h400080000, 1'b1, 8'd33},
    {8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 6'b111111, 36'hFFFFFFFFF, 1'b1, 8'd7}
  };

  function automatic string row_tag(input int r);
    case (r)
      0:  return "R10 R12 lone pin request";
      1:  return "R5 R4 high pin beats low pin";
      2:  return "R6 tie at low level";
      3:  return "R6 pin before internal";
      4:  return "R4 R5 converter high beats timer";
      5:  return "R7 global mask";
      6:  return "R3 R7 NMI through global mask";
      7:  return "R8 low mask passes high";
      8:  return "R8 low mask blocks low";
      9:  return "R4 serial group high beats DMA";
      10: return "R6 R12 DMA before serial";
      default: return "R3 NMI beats all high";
    endcase
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [8:0] exp);
    nchk++;
    if ({irq_req, irq_vec} !== exp) begin
      nerr++;
      $display("FAIL %s: got req=%0d vec=%0d, expected req=%0d vec=%0d",
               tag, irq_req, irq_vec, exp[8], exp[7:0]);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; nmi_n = 1'b1;
    irq_in = '0; periph_req = '0; mask_all = 1'b0; mask_low = 1'b0; irq_ack = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic enable_all();
    for (int a = 2; a < 8; a++) wr(3'(a), 8'hFF);
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    tick();
    irq_ack = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    nerr++;
    $display("FAIL watchdog: got run still active, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    tick();
    // Reset state
    do_reset();
    chk("R1 reset outputs", 9'h000);
    irq_in = 6'b000001; tick(); irq_in = '0; tick(); tick();
    chk("R1 enables off after reset", 9'h000);
    do_reset(); enable_all();
    irq_in = 6'b010010; tick(); irq_in = '0; tick();
    chk("R1 priorities low after reset", {1'b1, 8'd9});

    // Table walk
    for (int r = 0; r < NROW; r++) begin
      logic [69:0] v;
      v = TBL[r];
      do_reset(); enable_all();
      wr(3'd0, v[69:62]); wr(3'd1, v[61:54]);
      mask_all = v[53]; mask_low = v[52];
      nmi_n = ~v[51]; irq_in = v[50:45]; periph_req = v[44:9];
      tick();
      nmi_n = 1'b1; irq_in = '0; periph_req = '0;
      tick();
      chk(row_tag(r), v[8:0]);
    end

    // R9: disabled source not latched
    do_reset(); enable_all(); wr(3'd2, 8'hFE);
    irq_in = 6'b000001; tick(); irq_in = '0; tick(); tick();
    chk("R9 disabled source ignored", 9'h000);
    wr(3'd2, 8'hFF); tick(); tick();
    chk("R9 no grant after late enable", 9'h000);

    // R2: enable bit layout for the last sources
    do_reset(); wr(3'd7, 8'h02);
    periph_req = 36'hC00000000; tick(); periph_req = '0; tick();
    chk("R2 enable of source 42 only", {1'b1, 8'd49});

    // R11: hold, ack clears only granted, idle ack ignored
    do_reset(); enable_all();
    irq_in = 6'b001010; tick(); irq_in = '0; tick();
    chk("R11 first grant", {1'b1, 8'd9});
    tick(); tick();
    chk("R11 held without ack", {1'b1, 8'd9});
    ack_pulse();
    chk("R11 drop after ack", 9'h000 | {1'b0, 8'd9});
    tick();
    chk("R11 other source still pending", {1'b1, 8'd11});
    ack_pulse(); tick(); tick();
    chk("R11 drained", {1'b0, 8'd11});
    ack_pulse();
    irq_in = 6'b000100; tick(); irq_in = '0; tick();
    chk("R11 idle ack ignored", {1'b1, 8'd10});

    // R13: request during its own ack
    do_reset(); enable_all();
    irq_in = 6'b000001; tick(); tick();
    chk("R13 grant while held", {1'b1, 8'd8});
    ack_pulse();
    chk("R13 drop after ack", {1'b0, 8'd8});
    tick();
    chk("R13 set beats clear", {1'b1, 8'd8});
    irq_in = '0;

    // R3: NMI with nothing enabled, both masks, held low
    do_reset(); mask_all = 1'b1; mask_low = 1'b1;
    nmi_n = 1'b0; tick(); tick();
    chk("R3 NMI ignores masks and enables", {1'b1, 8'd7});
    ack_pulse(); tick(); tick();
    chk("R3 held low gives no second request", {1'b0, 8'd7});
    nmi_n = 1'b1; tick(); tick();
    chk("R3 rising edge ignored", {1'b0, 8'd7});

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule